// File: doc/BRIEF.md
# Periodic Real-Time Interrupt Generator

This block produces a steady periodic interrupt for system software. It counts bus cycles in a free-running period counter. The period is a power-of-two multiple of a base period, and a two-bit rate field picks the multiple. Each time a period completes, a real-time flag is raised. While that flag and a software enable are both set, the block holds its interrupt request high.

Software talks to the block through a small byte-wide register port with three registers. The rate register holds the rate field, and any write to it restarts the period from zero without raising the flag. The enable register holds the interrupt enable. The flag register holds the real-time flag, which software clears by writing a one to its bit. The counter keeps running whether or not software services the flag, so the period stays locked to the last restart.

Top module: `rti_gen`

## Requirements
- R1: The period is PERIOD_BASE × 2^rate bus cycles (8192, 16384, 32768 or 65536 by default). `rate` is bits [1:0] of the rate register at address 0, and those bits read back as written.
- R2: After a restart, the flag (bit 6 of the flag register at address 2) reads 0 for the first period−1 cycles and reads 1 once period cycles have passed.
- R3: Any write to the rate register restarts the period count from zero and never sets the flag. A restart landing on the last cycle of a period suppresses that period's flag.
- R4: Writing the flag register with bit 6 = 1 clears the flag. Writing it with bit 6 = 0 leaves the flag unchanged.
- R5: While reset is high and after it falls, the flag is 0, the rate field is 0 (shortest period) and the enable is 0.
- R6: `rti_irq` is 1 exactly when the flag is 1 and the enable (bit 6 of the enable register at address 1) is 1.
- R7: The period counter runs freely between restarts. A flag that is left set or cleared part-way through a period does not shift the next period end, which falls at 2 × period after the restart.
- R8: When a clearing write to the flag lands on the same cycle as the end of a period, the flag ends up set.
- R9: Register bits other than rate bits [1:0] and enable/flag bit 6 read as 0, and address 3 reads as 0 and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; one period count per rising edge |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe for the register port |
| bus_addr | input | 2 | Register select: 0 rate, 1 enable, 2 flag, 3 unused |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected register (combinational) |
| rti_irq | output | 1 | Interrupt request, high while flag and enable are both set |

## Verification
The hardest case to reach is a clearing write that lands on the very edge where a period ends. The stimulus gets there by restarting the period with a rate write and counting negative clock edges exactly. The clearing write is then issued so that its active edge is the third period boundary. The free-running property is reached the same way: the flag is cleared in the middle of a period, and the next set is checked one cycle before and at exactly twice the period. Random writes to the enable, flag and unused registers are kept away from any period boundary and checked against a bench model.

// File: rtl/rti_pkg.sv
package rti_pkg;

    localparam int DATA_W  = 8;
    localparam int ADDR_W  = 2;
    localparam int RTI_BIT = 6;
    localparam logic [DATA_W-1:0] RTI_MASK = DATA_W'(1) << RTI_BIT;

    typedef enum logic [ADDR_W-1:0] {
        REG_RATE   = 2'd0,
        REG_ENABLE = 2'd1,
        REG_FLAG   = 2'd2,
        REG_SPARE  = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic wr_rate;
        logic wr_enable;
        logic clr_flag;
    } reg_strobe_t;

    // Last count value of a period: base * 2^shift - 1
    function automatic logic [31:0] last_count(input logic [31:0] base,
                                               input logic [7:0]  shift);
        return (base << shift) - 32'd1;
    endfunction

endpackage

// File: rtl/rti_regs.sv
module rti_regs
    import rti_pkg::*;
#(
    parameter int RATE_W = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [DATA_W-1:0]   bus_wdata,
    input  logic                flag,
    output reg_strobe_t         strobe,
    output logic [RATE_W-1:0]   rate,
    output logic                enable,
    output logic [DATA_W-1:0]   bus_rdata
);

    reg_sel_e sel;

    always_comb begin
        sel              = reg_sel_e'(bus_addr);
        strobe.wr_rate   = bus_wr && (sel == REG_RATE);
        strobe.wr_enable = bus_wr && (sel == REG_ENABLE);
        strobe.clr_flag  = bus_wr && (sel == REG_FLAG) && |(bus_wdata & RTI_MASK);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rate   <= '0;
            enable <= 1'b0;
        end else begin
            if (strobe.wr_rate)
                rate <= bus_wdata[RATE_W-1:0];
            if (strobe.wr_enable)
                enable <= bus_wdata[RTI_BIT];
        end
    end

    always_comb begin
        bus_rdata = '0;
        unique case (sel)
            REG_RATE:   bus_rdata[RATE_W-1:0] = rate;
            REG_ENABLE: bus_rdata[RTI_BIT]    = enable;
            REG_FLAG:   bus_rdata[RTI_BIT]    = flag;
            REG_SPARE:  bus_rdata             = '0;
            default:    bus_rdata             = '0;
        endcase
    end

endmodule

// File: rtl/rti_period.sv
module rti_period
    import rti_pkg::*;
#(
    parameter int PERIOD_BASE = 8192,
    parameter int RATE_W      = 2,
    parameter int CNT_W       = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              restart,
    input  logic [RATE_W-1:0] rate,
    output logic [CNT_W-1:0]  cnt,
    output logic [CNT_W-1:0]  term,
    output logic              period_end
);

    logic at_term;

    always_comb begin
        term       = CNT_W'(last_count(32'(PERIOD_BASE), 8'(rate)));
        at_term    = (cnt == term);
        period_end = at_term && !restart;
    end

    always_ff @(posedge clk) begin
        if (rst || restart || at_term)
            cnt <= '0;
        else
            cnt <= cnt + CNT_W'(1);
    end

endmodule

// File: rtl/rti_flag.sv
module rti_flag (
    input  logic clk,
    input  logic rst,
    input  logic period_end,
    input  logic clr,
    input  logic enable,
    output logic flag,
    output logic irq
);

    always_ff @(posedge clk) begin
        if (rst)
            flag <= 1'b0;
        else if (period_end)
            flag <= 1'b1;
        else if (clr)
            flag <= 1'b0;
    end

    always_comb irq = flag && enable;

endmodule

// File: rtl/rti_gen.sv
module rti_gen
    import rti_pkg::*;
#(
    parameter int PERIOD_BASE = 8192,
    parameter int RATE_W      = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [1:0]        bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    output logic              rti_irq
);

    localparam int BASE_W    = $clog2(PERIOD_BASE);
    localparam int MAX_SHIFT = (1 << RATE_W) - 1;
    localparam int CNT_W     = BASE_W + MAX_SHIFT;

    reg_strobe_t       strobe;
    logic [RATE_W-1:0] rate;
    logic              enable;
    logic              flag;
    logic [CNT_W-1:0]  cnt;
    logic [CNT_W-1:0]  term;
    logic              period_end;

    rti_regs #(.RATE_W(RATE_W)) regs_i (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .flag      (flag),
        .strobe    (strobe),
        .rate      (rate),
        .enable    (enable),
        .bus_rdata (bus_rdata)
    );

    rti_period #(
        .PERIOD_BASE (PERIOD_BASE),
        .RATE_W      (RATE_W),
        .CNT_W       (CNT_W)
    ) period_i (
        .clk        (clk),
        .rst        (rst),
        .restart    (strobe.wr_rate),
        .rate       (rate),
        .cnt        (cnt),
        .term       (term),
        .period_end (period_end)
    );

    rti_flag flag_i (
        .clk        (clk),
        .rst        (rst),
        .period_end (period_end),
        .clr        (strobe.clr_flag),
        .enable     (enable),
        .flag       (flag),
        .irq        (rti_irq)
    );

endmodule

// File: rtl/rti_gen_chk.sv
module rti_gen_chk
    import rti_pkg::*;
#(
    parameter int RATE_W = 2,
    parameter int CNT_W  = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_wr,
    input logic [1:0]        bus_addr,
    input logic [7:0]        bus_wdata,
    input logic [RATE_W-1:0] rate,
    input logic              enable,
    input logic              flag,
    input logic [CNT_W-1:0]  cnt,
    input logic [CNT_W-1:0]  term,
    input logic              rti_irq
);

    logic rate_wr, flag_wr_one, flag_wr_zero;
    always_comb begin
        rate_wr      = bus_wr && (bus_addr == REG_RATE);
        flag_wr_one  = bus_wr && (bus_addr == REG_FLAG) && ((bus_wdata & RTI_MASK) != '0);
        flag_wr_zero = bus_wr && (bus_addr == REG_FLAG) && ((bus_wdata & RTI_MASK) == '0);
    end

    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
        cnt <= term); // R1

    AST_FLAG_AT_END: assert property (@(posedge clk) disable iff (rst)
        $rose(flag) |-> ($past(cnt) == $past(term))); // R2

    AST_RESTART: assert property (@(posedge clk) disable iff (rst)
        rate_wr |=> (cnt == '0)); // R3

    AST_RESTART_NO_SET: assert property (@(posedge clk) disable iff (rst)
        (rate_wr && !flag) |=> !flag); // R3

    AST_W1C: assert property (@(posedge clk) disable iff (rst)
        (flag_wr_one && (cnt != term)) |=> !flag); // R4

    AST_W0_KEEP: assert property (@(posedge clk) disable iff (rst)
        (flag_wr_zero && flag) |=> flag); // R4

    AST_RESET_STATE: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!flag && (rate == '0) && !enable)); // R5

    AST_IRQ_NEEDS_BOTH: assert property (@(posedge clk) disable iff (rst)
        rti_irq |-> (flag && enable)); // R6

    AST_FREE_RUN: assert property (@(posedge clk) disable iff (rst)
        (!rate_wr && (cnt != term)) |=> (cnt == $past(cnt) + CNT_W'(1))); // R7

    AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        (flag_wr_one && !rate_wr && (cnt == term)) |=> flag); // R8

endmodule

bind rti_gen rti_gen_chk #(.RATE_W(RATE_W), .CNT_W(CNT_W)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .rate      (rate),
    .enable    (enable),
    .flag      (flag),
    .cnt       (cnt),
    .term      (term),
    .rti_irq   (rti_irq)
);

// File: tb/rti_gen_tb.sv
module rti_gen_tb_top;

    localparam int BASE = 8192;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_wr = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic       rti_irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    bit exp_en   = 1'b0;
    bit exp_flag = 1'b0;

    always #5 clk = ~clk;

    rti_gen dut_i (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .rti_irq   (rti_irq)
    );

    function automatic int period_of(input int r);
        return BASE << r;
    endfunction

    function automatic logic [7:0] bit6(input bit v);
        return {1'b0, v, 6'b0};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    // called at a negative edge; the write lands on the next rising edge
    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check_flag(input string req, input bit exp);
        logic [7:0] d;
        rd(2'd2, d);
        check(req, 32'(d), 32'(bit6(exp)));
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        int p;
        void'($urandom(32'h1234_5eed));
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R5 reset state
        rd(2'd0, d); check("R5 rate", 32'(d), 32'h0);
        rd(2'd1, d); check("R5 enable", 32'(d), 32'h0);
        check_flag("R5 flag", 1'b0);
        check("R5 irq", 32'(rti_irq), 32'h0);

        // shortest rate, restart by write
        p = period_of(0);
        wr(2'd0, 8'h00);
        check_flag("R3 write sets no flag", 1'b0);
        wait_n(p - 1);
        check_flag("R2 before end", 1'b0);
        wait_n(1);
        check_flag("R1 R2 end of period", 1'b1);
        exp_flag = 1'b1;
        check("R6 irq disabled", 32'(rti_irq), 32'h0);
        wr(2'd1, 8'h40); exp_en = 1'b1;
        check("R6 irq enabled", 32'(rti_irq), 32'h1);
        wait_n(100);
        wr(2'd2, 8'hBF);
        check_flag("R4 write zero keeps", 1'b1);
        wr(2'd2, 8'h40); exp_flag = 1'b0;
        check_flag("R4 write one clears", 1'b0);
        check("R6 irq after clear", 32'(rti_irq), 32'h0);
        wait_n(p - 104);
        check_flag("R7 before second end", 1'b0);
        wait_n(1);
        check_flag("R7 second end", 1'b1);
        check("R6 irq second end", 32'(rti_irq), 32'h1);

        // R8: clear collides with the third period end
        wr(2'd2, 8'h40);
        check_flag("R4 clear before collision", 1'b0);
        wait_n(p - 2);
        wr(2'd2, 8'h40);
        check_flag("R8 set beats clear", 1'b1);
        exp_flag = 1'b1;

        // random register traffic away from period boundaries
        for (int i = 0; i < 300; i++) begin
            logic [1:0] a;
            logic [7:0] v;
            a = 2'(1 + ($urandom % 3));
            v = 8'($urandom);
            if (a == 2'd1) exp_en = v[6];
            if (a == 2'd2 && v[6]) exp_flag = 1'b0;
            wr(a, v);
            check("R6 irq random", 32'(rti_irq), 32'(exp_en & exp_flag));
            rd(2'd1, d); check("R9 enable readback", 32'(d), 32'(bit6(exp_en)));
            rd(2'd3, d); check("R9 spare reads zero", 32'(d), 32'h0);
            check_flag("R4 random flag", exp_flag);
        end

        // R3: mid-period restart, upper rate bits read zero
        wr(2'd2, 8'h40);
        wr(2'd0, {6'($urandom | 1), 2'b00});
        rd(2'd0, d); check("R9 rate upper bits", 32'(d), 32'h0);
        wait_n(5000);
        wr(2'd0, 8'h00);
        check_flag("R3 rewrite no flag", 1'b0);
        wait_n(p - 1);
        check_flag("R3 restarted before end", 1'b0);
        wait_n(1);
        check_flag("R3 restarted end", 1'b1);

        // R1 other rates
        for (int r = 1; r < 4; r++) begin
            p = period_of(r);
            wr(2'd2, 8'h40);
            wr(2'd0, 8'(r));
            rd(2'd0, d); check("R1 rate readback", 32'(d), 32'(r));
            wait_n(p - 1);
            check_flag("R1 longer period before end", 1'b0);
            wait_n(1);
            check_flag("R1 longer period end", 1'b1);
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule